// File: doc/BRIEF.md
# One-Shot Pulse Timer Channel

This block is a timer channel that produces one output pulse per start event. It holds a 10-bit up-counter, a compare register, a run bit and a sticky interrupt flag. The output pin is driven only when the configuration register selects one-shot operation. That happens when the mode field holds binary 10 and the pin-function field holds binary 11. In every other setting the pin stays low.

A pulse starts when the run bit goes from low to high. Software can raise it with a write. An edge on the external trigger pin can also raise it, but only in one-shot operation. The rising run bit zeroes the counter. The counter then advances once per prescaled tick. The pulse ends in one of two ways: software writes the run bit low, or the next count value equals the compare register. A compare match clears the run bit in hardware and sets the interrupt flag, so the compare value fixes the pulse width in ticks. Once the pulse ends, the count is held. It is zeroed again only at the next start.

Top module: `oneshot_timer`

## Requirements
- R1: The output `pulse_out` is high only while the run bit is high and the configuration holds mode field `ctl_wdata[3:2]` = 2'b10 and pin-function field `ctl_wdata[1:0]` = 2'b11. Every other encoding keeps it low. The counter still runs from a software start in those other encodings.
- R2: A software write of 1 (`run_we`=1, `run_wdata`=1) while the run bit is low sets the run bit and zeroes the count at the next clock edge.
- R3: In one-shot operation, a rising edge on `ext_trig` passes through two synchronizer flops and an edge detector. The pulse goes high at the third clock edge after the pin changes, with the count zeroed.
- R4: A software write of 0 while running clears the run bit at the next edge, which ends the pulse. The count is kept, not zeroed.
- R5: While running, each cycle with `tick` high advances the count by one, modulo 1024. When the advanced value equals the compare register, the run bit clears at that same edge. The pulse therefore lasts exactly `cmpa` ticks, or 1024 ticks when the compare value is 0.
- R6: A compare match sets `irq_flag`. The flag stays set until a cycle with `irq_clr` high clears it. If a match and `irq_clr` fall in the same cycle, the set wins.
- R7: The count changes only in two cases: it is zeroed at a rising edge of the run bit, and it advances on a tick while running. At all other times it holds its value.
- R8: A software start and a trigger edge in the same cycle give a single start. A software clear in the same cycle as a compare match gives a single trailing edge and still sets the flag.
- R9: After reset, the following are all zero: the output, the flag, the count, the compare register, the configuration and the synchronizer.
- R10: Outside one-shot operation, a trigger edge does not set the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the configuration register |
| ctl_wdata | input | 4 | Configuration: [3:2] mode field, [1:0] pin-function field |
| cmpa_we | input | 1 | Write strobe for the compare register |
| cmpa_wdata | input | 10 | New compare value |
| run_we | input | 1 | Software write strobe for the run bit |
| run_wdata | input | 1 | Value written to the run bit |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| tick | input | 1 | Prescaled count enable |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| pulse_out | output | 1 | Pulse output pin |
| irq_flag | output | 1 | Sticky compare-match interrupt flag |
| count | output | 10 | Current counter value |

## Verification
Pulses are started by software, by the trigger pin, and by both in the same cycle. Comparing the start latency and the zeroed count across these three cases separates the synchronizer path from the direct write path. Pulses are ended by a software clear, by a compare match, and by both together. These show whether the count is held or zeroed at the trailing edge, whether the width tracks the compare value (including the wrap case at compare value 0), and whether the flag is set only by a match. Runs with the configuration set to neighbouring encodings show the pin staying low while the counter still moves under software control. In the same encodings, the trigger pin is shown to start nothing. A long stretch of random writes, ticks and trigger toggles is then compared cycle by cycle with a behavioural model.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    localparam int CNT_W       = 10;
    localparam int SYNC_STAGES = 2;

    localparam logic [1:0] MODE_ONESHOT  = 2'b10;
    localparam logic [1:0] PINFN_ONESHOT = 2'b11;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] pinfn;
    } osh_cfg_t;

    typedef struct packed {
        logic sw_start;
        logic sw_stop;
        logic hw_start;
        logic match;
    } osh_evt_t;

    function automatic logic cfg_is_oneshot(input osh_cfg_t c);
        return (c.mode == MODE_ONESHOT) && (c.pinfn == PINFN_ONESHOT);
    endfunction

endpackage

// File: rtl/oneshot_trig_sync.sv
module oneshot_trig_sync #(
    parameter int STAGES = oneshot_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/oneshot_cfg_regs.sv
module oneshot_cfg_regs
    import oneshot_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic [3:0]    ctl_wdata,
    input  logic          cmpa_we,
    input  logic [CW-1:0] cmpa_wdata,
    output osh_cfg_t      cfg,
    output logic          oneshot_on,
    output logic [CW-1:0] cmpa
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            cmpa <= '0;
        end else begin
            if (ctl_we)  cfg  <= osh_cfg_t'(ctl_wdata);
            if (cmpa_we) cmpa <= cmpa_wdata;
        end
    end

    assign oneshot_on = cfg_is_oneshot(cfg);
endmodule

// File: rtl/oneshot_counter.sv
module oneshot_counter #(
    parameter int CW = oneshot_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_q,
    input  logic          start,
    input  logic          tick,
    input  logic [CW-1:0] cmpa,
    output logic [CW-1:0] count,
    output logic          match
);
    logic [CW-1:0] nxt;

    assign nxt   = count + 1'b1;
    assign match = run_q & tick & (nxt == cmpa);

    always_ff @(posedge clk) begin
        if (rst)                count <= '0;
        else if (start)         count <= '0;
        else if (run_q && tick) count <= nxt;
    end
endmodule

// File: rtl/oneshot_run_ctrl.sv
module oneshot_run_ctrl
    import oneshot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  osh_evt_t evt,
    input  logic     irq_clr,
    output logic     run_q,
    output logic     start,
    output logic     irq_flag
);
    logic run_d;

    always_comb begin
        if (run_q) run_d = ~(evt.match | evt.sw_stop);
        else       run_d = evt.sw_start | evt.hw_start;
    end

    assign start = ~run_q & run_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            run_q <= run_d;
            if (evt.match)    irq_flag <= 1'b1;
            else if (irq_clr) irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic [3:0]    ctl_wdata,
    input  logic          cmpa_we,
    input  logic [CW-1:0] cmpa_wdata,
    input  logic          run_we,
    input  logic          run_wdata,
    input  logic          irq_clr,
    input  logic          tick,
    input  logic          ext_trig,
    output logic          pulse_out,
    output logic          irq_flag,
    output logic [CW-1:0] count
);
    osh_cfg_t      cfg;
    osh_evt_t      evt;
    logic          oneshot_on;
    logic [CW-1:0] cmpa_q;
    logic          trig_rise;
    logic          run_q;
    logic          start;
    logic          match;

    oneshot_cfg_regs #(.CW(CW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .cmpa_we    (cmpa_we),
        .cmpa_wdata (cmpa_wdata),
        .cfg        (cfg),
        .oneshot_on (oneshot_on),
        .cmpa       (cmpa_q)
    );

    oneshot_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_trig),
        .rise (trig_rise)
    );

    always_comb begin
        evt.sw_start = run_we &  run_wdata;
        evt.sw_stop  = run_we & ~run_wdata;
        evt.hw_start = trig_rise & oneshot_on;
        evt.match    = match;
    end

    oneshot_run_ctrl u_run (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .irq_clr  (irq_clr),
        .run_q    (run_q),
        .start    (start),
        .irq_flag (irq_flag)
    );

    oneshot_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run_q (run_q),
        .start (start),
        .tick  (tick),
        .cmpa  (cmpa_q),
        .count (count),
        .match (match)
    );

    assign pulse_out = run_q & oneshot_on;
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
    parameter int CW = oneshot_pkg::CNT_W
) (
    input logic          clk,
    input logic          rst,
    input logic          run_we,
    input logic          run_wdata,
    input logic          irq_clr,
    input logic          tick,
    input logic          pulse_out,
    input logic          irq_flag,
    input logic [CW-1:0] count,
    input logic          run_q,
    input logic          oneshot_on,
    input logic [CW-1:0] cmpa_q
);
    // R1: pin low outside one-shot configuration
    a_r1_pin_low: assert property (@(posedge clk) disable iff (rst)
        !oneshot_on |-> !pulse_out);

    // R2: software start raises run with a zero count
    a_r2_sw_start: assert property (@(posedge clk) disable iff (rst)
        (!run_q && run_we && run_wdata) |=> (run_q && count == '0));

    // R4: software clear ends the run
    a_r4_sw_stop: assert property (@(posedge clk) disable iff (rst)
        (run_q && run_we && !run_wdata) |=> !run_q);

    // R5 and R6: compare match ends the run and raises the flag
    a_r5_match_stops: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && (CW'(count + 1'b1) == cmpa_q)) |=> (!run_q && irq_flag));

    // R6: flag is sticky without a clear
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R7: idle count holds unless a start occurs
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> (run_q || $stable(count)));
endmodule

bind oneshot_timer oneshot_timer_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_we     (run_we),
    .run_wdata  (run_wdata),
    .irq_clr    (irq_clr),
    .tick       (tick),
    .pulse_out  (pulse_out),
    .irq_flag   (irq_flag),
    .count      (count),
    .run_q      (run_q),
    .oneshot_on (oneshot_on),
    .cmpa_q     (cmpa_q)
);

// File: tb/oneshot_timer_bench.sv
`timescale 1ns/1ps
module oneshot_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic       cmpa_we = 1'b0;
    logic [9:0] cmpa_wdata = '0;
    logic       run_we = 1'b0;
    logic       run_wdata = 1'b0;
    logic       irq_clr = 1'b0;
    logic       tick = 1'b0;
    logic       ext_trig = 1'b0;
    logic       pulse_out;
    logic       irq_flag;
    logic [9:0] count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    oneshot_timer u_oneshot_timer (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata), .run_we(run_we),
        .run_wdata(run_wdata), .irq_clr(irq_clr), .tick(tick),
        .ext_trig(ext_trig), .pulse_out(pulse_out), .irq_flag(irq_flag),
        .count(count)
    );

    // behavioural reference model
    int m_run, m_cnt, m_cmpa, m_mode, m_fn, m_irq, s1, s2, s3;
    initial begin
        m_run = 0; m_cnt = 0; m_cmpa = 0; m_mode = 0; m_fn = 0; m_irq = 0;
        s1 = 0; s2 = 0; s3 = 0;
    end

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_cmpa = 0; m_mode = 0; m_fn = 0; m_irq = 0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            int spm, hw, nxt, match, nrun, ncnt;
            spm   = (m_mode == 2 && m_fn == 3) ? 1 : 0;
            hw    = (s2 == 1 && s3 == 0 && spm == 1) ? 1 : 0;
            nxt   = (m_cnt + 1) % 1024;
            match = (m_run == 1 && tick && nxt == m_cmpa) ? 1 : 0;
            if (m_run == 1) nrun = (match == 1 || (run_we && !run_wdata)) ? 0 : 1;
            else            nrun = ((run_we && run_wdata) || hw == 1) ? 1 : 0;
            if (m_run == 0 && nrun == 1)  ncnt = 0;
            else if (m_run == 1 && tick)  ncnt = nxt;
            else                          ncnt = m_cnt;
            if (match == 1)   m_irq = 1;
            else if (irq_clr) m_irq = 0;
            m_run = nrun;
            m_cnt = ncnt;
            s3 = s2; s2 = s1; s1 = int'(ext_trig);
            if (ctl_we)  begin m_mode = int'(ctl_wdata[3:2]); m_fn = int'(ctl_wdata[1:0]); end
            if (cmpa_we) m_cmpa = int'(cmpa_wdata);
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired: actual cycle %0d expected below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // every-clock comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            int exp_pulse;
            exp_pulse = (m_run == 1 && m_mode == 2 && m_fn == 3) ? 1 : 0;
            checks++;
            if (int'(pulse_out) != exp_pulse) begin
                errors++;
                $display("FAIL R1 model pulse_out: actual %0d expected %0d", pulse_out, exp_pulse);
            end
            checks++;
            if (int'(count) != m_cnt) begin
                errors++;
                $display("FAIL R7 model count: actual %0d expected %0d", count, m_cnt);
            end
            checks++;
            if (int'(irq_flag) != m_irq) begin
                errors++;
                $display("FAIL R6 model irq_flag: actual %0d expected %0d", irq_flag, m_irq);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_run(input logic v);
        run_we = 1'b1; run_wdata = v;
        step(1);
        run_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [1:0] mode, input logic [1:0] fn);
        ctl_we = 1'b1; ctl_wdata = {mode, fn};
        step(1);
        ctl_we = 1'b0;
    endtask

    task automatic wr_cmpa(input int v);
        cmpa_we = 1'b1; cmpa_wdata = 10'(v);
        step(1);
        cmpa_we = 1'b0;
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        check("R9 reset pulse_out", int'(pulse_out), 0);
        check("R9 reset irq_flag", int'(irq_flag), 0);
        check("R9 reset count", int'(count), 0);

        // R2 / R5 / R6: software start, match after 5 ticks
        wr_ctl(2'b10, 2'b11);
        wr_cmpa(5);
        tick = 1'b1;
        wr_run(1'b1);
        check("R2 start pulse high", int'(pulse_out), 1);
        check("R2 start count zero", int'(count), 0);
        step(4);
        check("R5 still high at 4", int'(pulse_out), 1);
        check("R5 count at 4", int'(count), 4);
        step(1);
        check("R5 low after match", int'(pulse_out), 0);
        check("R5 count held at match", int'(count), 5);
        check("R6 flag set by match", int'(irq_flag), 1);
        step(3);
        check("R6 flag sticky", int'(irq_flag), 1);
        clr_irq();
        check("R6 flag cleared", int'(irq_flag), 0);

        // R4 / R7: software stop holds count, restart zeroes
        wr_cmpa(100);
        tick = 1'b0;
        wr_run(1'b1);
        check("R2 second start count", int'(count), 0);
        tick = 1'b1;
        step(2);
        check("R7 count advances", int'(count), 2);
        tick = 1'b0;
        wr_run(1'b0);
        check("R4 stop pulse low", int'(pulse_out), 0);
        check("R4 stop count kept", int'(count), 2);
        tick = 1'b1;
        step(5);
        check("R7 idle count held", int'(count), 2);
        check("R4 no flag on sw stop", int'(irq_flag), 0);
        wr_run(1'b1);
        check("R7 restart zeroes", int'(count), 0);
        tick = 1'b0;
        wr_run(1'b0);

        // R3: external trigger start
        ext_trig = 1'b1;
        step(2);
        check("R3 not yet high", int'(pulse_out), 0);
        step(1);
        check("R3 high at third edge", int'(pulse_out), 1);
        check("R3 count zero", int'(count), 0);
        ext_trig = 1'b0;
        wr_run(1'b0);
        step(4);

        // R8: software and trigger start in the same cycle
        ext_trig = 1'b1;
        step(2);
        wr_run(1'b1);
        check("R8 joint start high", int'(pulse_out), 1);
        check("R8 joint start count", int'(count), 0);
        tick = 1'b1;
        step(2);
        check("R8 single start count", int'(count), 2);
        ext_trig = 1'b0;
        tick = 1'b0;
        wr_run(1'b0);
        step(3);

        // R8: match and software clear in the same cycle
        wr_cmpa(3);
        wr_run(1'b1);
        tick = 1'b1;
        step(2);
        wr_run(1'b0);
        check("R8 joint stop low", int'(pulse_out), 0);
        check("R8 joint stop count", int'(count), 3);
        check("R8 joint stop flag", int'(irq_flag), 1);
        step(1);
        check("R8 stays low", int'(pulse_out), 0);
        clr_irq();

        // R1 / R10: neighbouring encodings
        tick = 1'b0;
        wr_cmpa(100);
        wr_ctl(2'b10, 2'b10);
        wr_run(1'b1);
        tick = 1'b1;
        step(3);
        check("R1 pin low in other fn", int'(pulse_out), 0);
        check("R1 counter runs", int'(count), 3);
        tick = 1'b0;
        wr_run(1'b0);
        wr_ctl(2'b00, 2'b11);
        tick = 1'b1;
        ext_trig = 1'b1;
        step(5);
        check("R10 trigger ignored count", int'(count), 3);
        check("R10 trigger ignored pin", int'(pulse_out), 0);
        ext_trig = 1'b0;
        step(3);

        // R5: compare value 0 gives 1024 ticks
        tick = 1'b0;
        wr_ctl(2'b10, 2'b11);
        wr_cmpa(0);
        tick = 1'b1;
        wr_run(1'b1);
        step(1023);
        check("R5 wrap still high", int'(pulse_out), 1);
        check("R5 wrap count", int'(count), 1023);
        step(1);
        check("R5 wrap low", int'(pulse_out), 0);
        check("R5 wrap count zero", int'(count), 0);
        check("R6 wrap flag", int'(irq_flag), 1);

        // random phase, compared with the model every clock
        for (int i = 0; i < 4000; i++) begin
            tick      = ($urandom % 4) != 0;
            run_we    = ($urandom % 20) == 0;
            run_wdata = ($urandom % 2) == 0;
            irq_clr   = ($urandom % 10) == 0;
            if (($urandom % 15) == 0) ext_trig = ~ext_trig;
            ctl_we    = ($urandom % 200) == 0;
            ctl_wdata = (($urandom % 4) == 0) ? 4'($urandom) : 4'b1011;
            cmpa_we   = ($urandom % 50) == 0;
            cmpa_wdata = 10'($urandom % 40);
            step(1);
        end
        run_we = 1'b0; ctl_we = 1'b0; cmpa_we = 1'b0; irq_clr = 1'b0;
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule